// File: doc/BRIEF.md
# Processor Clock Source Switch Sequencer

This block moves a processor clock between a fixed 26 MHz reference and three PLL-derived rates (370, 540 and 720 MHz). A request names the target rate in MHz. When the block is idle and the target is a known rate other than the current one, it accepts the request. It then runs the PLL power sequence with timed settling waits, steps the two clock-source mux fields in the order that suits the direction of the switch, and loads the PLL divider word. The analog PLL and the clock muxes themselves are outside the block. Their control fields are registered outputs of this block.

The settling waits are counted from an external free-running counter, `tmr_count`, which advances 13 counts per microsecond. Each wait records the counter value when it starts and ends once the modular difference between the live value and that start value reaches the required number of counts. This keeps the wait correct when the counter wraps. `busy` is high from acceptance until the last control write. `done` pulses for one cycle with that write.

Top module: `clkswitch_seq`

## Requirements
- R1: After reset the outputs are as follows: `cur_idx`=0 (26 MHz), `busy`=0, `done`=0, `clk_gate`=1, `pll_pwr`=0, `pll_iso`=1, `pll_en`=0, both mux selects 0, both update strobes 0, and `pll_div`=0.
- R2: Targets decode as 26→index 0, 370→1, 540→2 and 720→3. The divider words are 0x831c7628 for index 1, 0x8214c4ed for index 2 and 0x821bb13c for index 3.
- R3: A switch to a PLL rate runs the power-up steps in this order. The cycle after acceptance, `clk_gate` falls and `pll_pwr` rises. Exactly 13·1+1 = 14 cycles later `pll_iso` falls. A further 14 cycles later `pll_en` rises.
- R4: On the PLL path, 13·20+1 = 261 cycles after `pll_en` rises, mux A becomes 8 with a one-cycle `mux_a_upd`. The next cycle mux B becomes 7 with a one-cycle `mux_b_upd`. The cycle after that, `pll_div` takes the target's word, `cur_idx` takes the target, `busy` falls and `done` is high for exactly one cycle.
- R5: A switch to 26 MHz works as follows. The cycle after acceptance, mux B becomes 0 with `mux_b_upd`. The next cycle mux A becomes 0 with `mux_a_upd`. The cycle after that, `pll_en` falls. 14 cycles later `pll_iso` rises. 14 cycles after that `pll_pwr` falls, together with `done` and the update of `cur_idx`. `clk_gate` and `pll_div` keep their values.
- R6: A request for the current rate, or for a rate not listed in R2, is ignored: `busy` stays low and no output changes.
- R7: A request made while `busy` is high is ignored and is not queued. The switch in progress ends with its own target.
- R8: A switch from one PLL rate to another runs the full R3/R4 path and ends with the new divider word.
- R9: The waits keep their R3/R5 lengths when `tmr_count` wraps past its maximum value during a wait.
- R10: `pll_en` is never high unless `pll_pwr` is high and `pll_iso` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_count | input | 32 | Free-running counter, 13 counts per microsecond |
| req_valid | input | 1 | Switch request strobe |
| req_mhz | input | 10 | Requested rate in MHz |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle pulse with the final write of a switch |
| cur_idx | output | 2 | Index of the current rate (R2 encoding) |
| clk_gate | output | 1 | Clock-gate control, 1 = gated |
| pll_pwr | output | 1 | PLL power-on control |
| pll_iso | output | 1 | PLL output isolation control |
| pll_en | output | 1 | PLL enable control |
| mux_a_sel | output | 4 | Clock mux A select (8 = PLL, 0 = reference) |
| mux_a_upd | output | 1 | Mux A update strobe |
| mux_b_sel | output | 4 | Clock mux B select (7 = PLL, 0 = reference) |
| mux_b_upd | output | 1 | Mux B update strobe |
| pll_div | output | 32 | PLL divider word |

## Verification
Each control step has a fixed cycle offset from the acceptance edge. The offsets are 1, 15, 29, 290, 291 and 292 on the upward path, and 1, 2, 3, 17 and 31 on the downward path. The bench derives these offsets from 13·µs+1 per wait. It drives inputs and samples outputs on the falling edge. It checks each output both one cycle before its due edge (still at the old value) and at the due edge (new value). Requests that should be ignored are followed by several cycles of checks that `busy` stays low and that every control output is unchanged.

// File: rtl/clkswitch_pkg.sv
package clkswitch_pkg;

  localparam int NUM_TGT   = 4;
  localparam int IDX_W     = 2;
  localparam int MHZ_W     = 10;
  localparam int SEL_W     = 4;
  localparam int DIV_W     = 32;
  localparam logic [SEL_W-1:0] SEL_A_PLL = 4'd8;
  localparam logic [SEL_W-1:0] SEL_B_PLL = 4'd7;
  localparam logic [SEL_W-1:0] SEL_REF   = 4'd0;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_UP_PWR, ST_UP_W1, ST_UP_ISO, ST_UP_W2, ST_UP_EN, ST_UP_W3,
    ST_SEL_A, ST_SEL_B, ST_DIV,
    ST_DN_B, ST_DN_A, ST_DN_EN, ST_DN_W1, ST_DN_ISO, ST_DN_W2, ST_DN_PWR
  } seq_state_t;

  // Rate in MHz for each target index; index 0 is the reference.
  function automatic logic [MHZ_W-1:0] mhz_of(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd1:    return 10'd370;
      2'd2:    return 10'd540;
      2'd3:    return 10'd720;
      default: return 10'd26;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] div_word(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd1:    return 32'h831c_7628;
      2'd2:    return 32'h8214_c4ed;
      2'd3:    return 32'h821b_b13c;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int ticks_for(input int us, input int per_us);
    return us * per_us;
  endfunction

endpackage

// File: rtl/clkswitch_decode.sv
module clkswitch_decode
  import clkswitch_pkg::*;
(
  input  logic [MHZ_W-1:0] mhz,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [NUM_TGT-1:0] match;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_cmp
    assign match[g] = (mhz == mhz_of(IDX_W'(g)));
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  // The rate table must never give two indices for one request.
  always_comb begin
    assert_match_unique_R2: assert ($onehot0(match));
  end

endmodule

// File: rtl/clkswitch_delay.sv
module clkswitch_delay
  import clkswitch_pkg::*;
#(
  parameter int TMR_W        = 32,
  parameter int TICKS_PER_US = 13,
  parameter int SETTLE_US    = 1,
  parameter int LOCK_US      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr,
  input  logic             arm,
  input  logic             use_lock,
  output logic             expired
);

  localparam logic [TMR_W-1:0] SETTLE_TICKS = TMR_W'(ticks_for(SETTLE_US, TICKS_PER_US));
  localparam logic [TMR_W-1:0] LOCK_TICKS   = TMR_W'(ticks_for(LOCK_US, TICKS_PER_US));

  logic [TMR_W-1:0] t_start;
  logic [TMR_W-1:0] limit;
  logic [TMR_W-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_start <= '0;
      limit   <= '0;
    end else if (arm) begin
      t_start <= tmr;
      limit   <= use_lock ? LOCK_TICKS : SETTLE_TICKS;
    end
  end

  // Modular difference: correct across a counter wrap.
  assign elapsed = tmr - t_start;
  assign expired = (elapsed >= limit);

  // The window length is only ever one of the two configured values.
  assert_limit_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arm) |-> (limit == SETTLE_TICKS || limit == LOCK_TICKS));

endmodule

// File: rtl/clkswitch_seq.sv
module clkswitch_seq
  import clkswitch_pkg::*;
#(
  parameter int TMR_W        = 32,
  parameter int TICKS_PER_US = 13,
  parameter int SETTLE_US    = 1,
  parameter int LOCK_US      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr_count,
  input  logic             req_valid,
  input  logic [MHZ_W-1:0] req_mhz,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] cur_idx,
  output logic             clk_gate,
  output logic             pll_pwr,
  output logic             pll_iso,
  output logic             pll_en,
  output logic [SEL_W-1:0] mux_a_sel,
  output logic             mux_a_upd,
  output logic [SEL_W-1:0] mux_b_sel,
  output logic             mux_b_upd,
  output logic [DIV_W-1:0] pll_div
);

  seq_state_t       state;
  logic [IDX_W-1:0] tgt_idx;
  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic             accept;
  logic             tmr_arm;
  logic             tmr_lock;
  logic             tmr_expired;

  clkswitch_decode u_decode (
    .mhz (req_mhz),
    .hit (dec_hit),
    .idx (dec_idx)
  );

  clkswitch_delay #(
    .TMR_W        (TMR_W),
    .TICKS_PER_US (TICKS_PER_US),
    .SETTLE_US    (SETTLE_US),
    .LOCK_US      (LOCK_US)
  ) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr      (tmr_count),
    .arm      (tmr_arm),
    .use_lock (tmr_lock),
    .expired  (tmr_expired)
  );

  // Internal events, named for the assertions.
  assign accept   = (state == ST_IDLE) && req_valid && dec_hit && (dec_idx != cur_idx);
  assign tmr_arm  = (state == ST_UP_PWR) || (state == ST_UP_ISO) || (state == ST_UP_EN) ||
                    (state == ST_DN_EN)  || (state == ST_DN_ISO);
  assign tmr_lock = (state == ST_UP_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tgt_idx   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cur_idx   <= '0;
      clk_gate  <= 1'b1;
      pll_pwr   <= 1'b0;
      pll_iso   <= 1'b1;
      pll_en    <= 1'b0;
      mux_a_sel <= SEL_REF;
      mux_a_upd <= 1'b0;
      mux_b_sel <= SEL_REF;
      mux_b_upd <= 1'b0;
      pll_div   <= '0;
    end else begin
      done      <= 1'b0;
      mux_a_upd <= 1'b0;
      mux_b_upd <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            busy    <= 1'b1;
            tgt_idx <= dec_idx;
            state   <= (dec_idx != '0) ? ST_UP_PWR : ST_DN_B;
          end
        end
        // Upward path: power, isolation, enable, lock wait.
        ST_UP_PWR: begin
          clk_gate <= 1'b0;
          pll_pwr  <= 1'b1;
          state    <= ST_UP_W1;
        end
        ST_UP_W1:  if (tmr_expired) state <= ST_UP_ISO;
        ST_UP_ISO: begin
          pll_iso <= 1'b0;
          state   <= ST_UP_W2;
        end
        ST_UP_W2:  if (tmr_expired) state <= ST_UP_EN;
        ST_UP_EN: begin
          pll_en <= 1'b1;
          state  <= ST_UP_W3;
        end
        ST_UP_W3:  if (tmr_expired) state <= ST_SEL_A;
        ST_SEL_A: begin
          mux_a_sel <= SEL_A_PLL;
          mux_a_upd <= 1'b1;
          state     <= ST_SEL_B;
        end
        ST_SEL_B: begin
          mux_b_sel <= SEL_B_PLL;
          mux_b_upd <= 1'b1;
          state     <= ST_DIV;
        end
        ST_DIV: begin
          pll_div <= div_word(tgt_idx);
          cur_idx <= tgt_idx;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        // Downward path: muxes in reverse order, then power down.
        ST_DN_B: begin
          mux_b_sel <= SEL_REF;
          mux_b_upd <= 1'b1;
          state     <= ST_DN_A;
        end
        ST_DN_A: begin
          mux_a_sel <= SEL_REF;
          mux_a_upd <= 1'b1;
          state     <= ST_DN_EN;
        end
        ST_DN_EN: begin
          pll_en <= 1'b0;
          state  <= ST_DN_W1;
        end
        ST_DN_W1:  if (tmr_expired) state <= ST_DN_ISO;
        ST_DN_ISO: begin
          pll_iso <= 1'b1;
          state   <= ST_DN_W2;
        end
        ST_DN_W2:  if (tmr_expired) state <= ST_DN_PWR;
        ST_DN_PWR: begin
          pll_pwr <= 1'b0;
          cur_idx <= tgt_idx;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_en_needs_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> (pll_pwr && !pll_iso));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_accept_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);

  assert_idx_moves_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> done);

  assert_strobe_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_a_upd || mux_b_upd) |-> busy);

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mux_a_upd && mux_b_upd));

endmodule

// File: tb/clkswitch_seq_test.sv
module clkswitch_seq_test;

  localparam int SET_GAP  = 13 * 1 + 1;
  localparam int LOCK_GAP = 13 * 20 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt = 32'd0;
  logic [31:0] off = 32'd0;
  logic [31:0] tmr_count;
  logic        req_valid = 1'b0;
  logic [9:0]  req_mhz = 10'd0;
  logic        busy, done, clk_gate, pll_pwr, pll_iso, pll_en;
  logic        mux_a_upd, mux_b_upd;
  logic [1:0]  cur_idx;
  logic [3:0]  mux_a_sel, mux_b_sel;
  logic [31:0] pll_div;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 32'd1;
  assign tmr_count = cnt + off;

  clkswitch_seq uut (
    .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count),
    .req_valid(req_valid), .req_mhz(req_mhz),
    .busy(busy), .done(done), .cur_idx(cur_idx),
    .clk_gate(clk_gate), .pll_pwr(pll_pwr), .pll_iso(pll_iso), .pll_en(pll_en),
    .mux_a_sel(mux_a_sel), .mux_a_upd(mux_a_upd),
    .mux_b_sel(mux_b_sel), .mux_b_upd(mux_b_upd), .pll_div(pll_div)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_mhz(input int i);
    return (i == 1) ? 10'd370 : (i == 2) ? 10'd540 : (i == 3) ? 10'd720 : 10'd26;
  endfunction

  function automatic logic [31:0] exp_word(input int i);
    return (i == 1) ? 32'h831c7628 : (i == 2) ? 32'h8214c4ed :
           (i == 3) ? 32'h821bb13c : 32'h0;
  endfunction

  function automatic logic [31:0] snap();
    return {18'd0, clk_gate, pll_pwr, pll_iso, pll_en, mux_a_sel, mux_b_sel, cur_idx};
  endfunction

  // Called at a falling edge; returns one cycle after the accepting edge.
  task automatic issue(input logic [9:0] m);
    req_valid = 1'b1;
    req_mhz   = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_up(input int i, input bit fresh);
    logic p_iso, p_en;
    logic [3:0] p_a, p_b;
    p_iso = pll_iso; p_en = pll_en; p_a = mux_a_sel; p_b = mux_b_sel;
    issue(exp_mhz(i));
    chk("R3 busy at accept", busy, 1);
    @(negedge clk);
    chk("R3 gate cleared", clk_gate, 0);
    chk("R3 power on", pll_pwr, 1);
    if (fresh) chk("R3 iso still set", pll_iso, 1);
    repeat (SET_GAP - 1) @(negedge clk);
    chk("R3 iso before settle", pll_iso, p_iso);
    @(negedge clk);
    chk("R3 iso cleared", pll_iso, 0);
    repeat (SET_GAP - 1) @(negedge clk);
    chk("R3 en before settle", pll_en, p_en);
    @(negedge clk);
    chk("R3 en set", pll_en, 1);
    repeat (LOCK_GAP - 1) @(negedge clk);
    chk("R4 mux A before lock", mux_a_sel, p_a);
    chk("R4 busy during lock", busy, 1);
    @(negedge clk);
    chk("R4 mux A pll", mux_a_sel, 8);
    chk("R4 mux A strobe", mux_a_upd, 1);
    chk("R4 mux B not yet", mux_b_sel, p_b);
    @(negedge clk);
    chk("R4 mux B pll", mux_b_sel, 7);
    chk("R4 mux B strobe", mux_b_upd, 1);
    chk("R4 mux A strobe ends", mux_a_upd, 0);
    @(negedge clk);
    chk("R4 divider word", pll_div, exp_word(i));
    chk("R4 done", done, 1);
    chk("R4 busy low", busy, 0);
    chk("R4 cur idx", cur_idx, i);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
  endtask

  task automatic run_down();
    logic [31:0] p_div;
    p_div = pll_div;
    issue(10'd26);
    chk("R5 busy at accept", busy, 1);
    @(negedge clk);
    chk("R5 mux B ref", mux_b_sel, 0);
    chk("R5 mux B strobe", mux_b_upd, 1);
    chk("R5 mux A still pll", mux_a_sel, 8);
    @(negedge clk);
    chk("R5 mux A ref", mux_a_sel, 0);
    chk("R5 mux A strobe", mux_a_upd, 1);
    @(negedge clk);
    chk("R5 en cleared", pll_en, 0);
    chk("R5 iso still clear", pll_iso, 0);
    repeat (SET_GAP - 1) @(negedge clk);
    chk("R5 iso before settle", pll_iso, 0);
    @(negedge clk);
    chk("R5 iso set", pll_iso, 1);
    chk("R5 power kept", pll_pwr, 1);
    repeat (SET_GAP - 1) @(negedge clk);
    chk("R5 power before settle", pll_pwr, 1);
    @(negedge clk);
    chk("R5 power off", pll_pwr, 0);
    chk("R5 done", done, 1);
    chk("R5 busy low", busy, 0);
    chk("R5 cur idx", cur_idx, 0);
    chk("R5 gate kept", clk_gate, 0);
    chk("R5 divider kept", pll_div, p_div);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
  endtask

  task automatic ignored(input logic [9:0] m, input string tag);
    logic [31:0] s, d;
    s = snap(); d = pll_div;
    issue(m);
    for (int k = 0; k < 4; k++) begin
      chk({tag, " busy stays low"}, busy, 0);
      chk({tag, " outputs unchanged"}, snap(), s);
      chk({tag, " divider unchanged"}, pll_div, d);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur idx", cur_idx, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 gate", clk_gate, 1);
    chk("R1 power", pll_pwr, 0);
    chk("R1 iso", pll_iso, 1);
    chk("R1 en", pll_en, 0);
    chk("R1 muxes", {mux_a_sel, mux_b_sel}, 0);
    chk("R1 strobes", {mux_a_upd, mux_b_upd}, 0);
    chk("R1 divider", pll_div, 0);

    ignored(10'd26, "R6 same rate");
    ignored(10'd100, "R6 unknown 100");
    ignored(10'd369, "R6 unknown 369");
    ignored(10'd1023, "R6 unknown 1023");

    // R2: every PLL rate from the reference and back.
    for (int i = 1; i < 4; i++) begin
      run_up(i, 1'b1);
      ignored(exp_mhz(i), "R6 current pll rate");
      run_down();
    end

    // R8: PLL to PLL switches.
    run_up(1, 1'b1);
    run_up(3, 1'b0);
    run_up(2, 1'b0);
    run_down();

    // R9: counter wraps inside the first wait.
    off = 32'hFFFF_FFF8 - cnt;
    run_up(3, 1'b1);
    off = 32'hFFFF_FFFA - cnt;
    run_down();

    // R7: requests during a switch are dropped.
    issue(10'd540);
    repeat (4) @(negedge clk);
    issue(10'd720);
    repeat (40) @(negedge clk);
    issue(10'd26);
    for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    chk("R7 target kept", cur_idx, 2);
    chk("R7 divider kept", pll_div, exp_word(2));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7 nothing queued", busy, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule